// File: doc/BRIEF.md
# Parallel Metronome Phase Tracker

This block holds a bank of free-running metronomes, each a phase accumulator that advances by its own step value on every sample tick. A step is a fraction of one full period, so the step sets the tempo. When the accumulator carries past full scale, that metronome emits a one-cycle beat pulse. Several metronomes run side by side at different tempos, and a tempo-search controller watches how well each one lines up with the music.

A beat detector upstream broadcasts beat events to every metronome at once. Each event carries an 8-bit confidence. On an event, every metronome takes its current phase as a signed error, where phase zero is the beat position. It then pulls its phase toward zero by the error times the confidence, scaled down by a fixed gain shift. The errors leave on a serial report port, one metronome per cycle in index order. A beat event that arrives while a report burst is still running is held and applied once the burst ends. The controller can write a new step for any metronome. The new step waits until that metronome's next wrap, so no beat pulse is lost or doubled.

FSM states of the report sequencer: `S_IDLE` (waiting; a beat event or a held event fires here) and `S_SEND` (one report beat per cycle). Transitions: `S_IDLE -> S_SEND` when an event fires; `S_SEND -> S_IDLE` after the report for the last index; `S_SEND -> S_SEND` otherwise; `S_IDLE -> S_IDLE` when nothing fires.

Top module: `met_tracker`

## Requirements
- R1: On each cycle with `sample_tick_i` high, metronome i adds its step to its PHASE_W-bit phase. When the sum carries out of PHASE_W bits, `met_tick_o[i]` is high for exactly the following cycle. Reset steps are STEP_BASE + i*STEP_INC.
- R2: After reset, all phases are zero, `met_tick_o` is all zero and `rep_valid_o` is low. A first beat event before any tick reports an error of 0 for every metronome.
- R3: On a beat event, the error recorded for each metronome is its phase read as a two's-complement signed value. This folds the error into the range from minus half a period up to just under plus half a period.
- R4: On a beat event, the new phase is phase minus floor(error * confidence / 2^GAIN_SH), with confidence unsigned. A confidence of 0 leaves every phase unchanged.
- R5: When a beat event and a sample tick land in the same cycle, the correction is applied first and the step is then added to the corrected phase. The carry of that addition gives the beat pulse.
- R6: In the cycle after an event fires, `rep_valid_o` goes high for NUM_MET consecutive cycles. `rep_idx_o` runs 0, 1, ..., NUM_MET-1 and `rep_err_o` carries that metronome's error. `rep_valid_o` is low in the cycle after the last index.
- R7: A beat event that arrives during a report burst is held, with its confidence. It fires in the first idle cycle after the burst, using the phases at that moment, and its own burst follows in the next cycle.
- R8: A step written with `tempo_wr_i` for index `tempo_idx_i` takes effect after that metronome's next wrap. The wrapping addition itself still uses the old step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick_i | input | 1 | Sample tick; advances every phase by its step |
| beat_valid_i | input | 1 | Beat event from the detector |
| beat_conf_i | input | CONF_W | Unsigned confidence of the beat event |
| tempo_wr_i | input | 1 | Step reload strobe |
| tempo_idx_i | input | IDX_W | Metronome index for the reload |
| tempo_step_i | input | PHASE_W | New phase step |
| met_tick_o | output | NUM_MET | Per-metronome beat pulse |
| rep_valid_o | output | 1 | Report beat valid |
| rep_idx_o | output | IDX_W | Index of the reported metronome |
| rep_err_o | output | PHASE_W | Signed phase error of that metronome |

## Verification
The hardest case to reach is a beat held behind a running burst. To reach it, the bench raises `beat_valid_i` in the middle of a report and then confirms that the correction lands in the idle cycle after the burst, using the phases as they stand then. A tempo reload can only be seen at a phase wrap. The bench therefore runs long tick trains after a reload and compares every cycle of `met_tick_o` against a phase model that switches steps only on the wrap. The error fold is reached by advancing the fastest metronome past half a period before an event.

// File: rtl/met_pkg.sv
package met_pkg;
    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_SEND = 1'b1
    } rpt_state_t;
endpackage

// File: rtl/met_osc.sv
module met_osc #(
    parameter int PHASE_W  = 16,
    parameter int CONF_W   = 8,
    parameter int GAIN_SH  = 8,
    parameter int RST_STEP = 1024
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               fire_i,
    input  logic [CONF_W-1:0]  conf_i,
    input  logic               wr_i,
    input  logic [PHASE_W-1:0] wr_step_i,
    output logic               tick_o,
    output logic [PHASE_W-1:0] err_o
);
    localparam int PROD_W = PHASE_W + CONF_W + 1;

    logic [PHASE_W-1:0] phase_q, step_q, pend_q;
    logic               pend_v_q;
    logic signed [PROD_W-1:0] err_ext, conf_ext, prod, scaled;
    logic [PHASE_W-1:0] base;
    logic [PHASE_W:0]   sum;
    logic               wrap;

    always_comb begin
        err_ext  = PROD_W'($signed(phase_q));
        conf_ext = PROD_W'($signed({1'b0, conf_i}));
        prod     = err_ext * conf_ext;
        scaled   = prod >>> GAIN_SH;
        base     = fire_i ? (phase_q - scaled[PHASE_W-1:0]) : phase_q;
        sum      = {1'b0, base} + (tick_i ? {1'b0, step_q} : '0);
        wrap     = tick_i & sum[PHASE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q  <= '0;
            step_q   <= PHASE_W'(RST_STEP);
            pend_q   <= '0;
            pend_v_q <= 1'b0;
            tick_o   <= 1'b0;
            err_o    <= '0;
        end else begin
            phase_q <= sum[PHASE_W-1:0];
            tick_o  <= wrap;
            if (fire_i)
                err_o <= phase_q;
            if (wrap && pend_v_q)
                step_q <= pend_q;
            if (wr_i) begin
                pend_q   <= wr_step_i;
                pend_v_q <= 1'b1;
            end else if (wrap) begin
                pend_v_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/met_rpt_seq.sv
module met_rpt_seq
    import met_pkg::*;
#(
    parameter int NUM_MET = 4,
    parameter int CONF_W  = 8,
    parameter int IDX_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_valid_i,
    input  logic [CONF_W-1:0] beat_conf_i,
    output logic              fire_o,
    output logic [CONF_W-1:0] fire_conf_o,
    output logic              rep_valid_o,
    output logic [IDX_W-1:0]  rep_idx_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_MET - 1);

    rpt_state_t        state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic              held_q;
    logic [CONF_W-1:0] held_conf_q;

    always_comb begin
        fire_o      = (state_q == S_IDLE) && (held_q || beat_valid_i);
        fire_conf_o = held_q ? held_conf_q : beat_conf_i;
        state_d     = state_q;
        unique case (state_q)
            S_IDLE: if (fire_o) state_d = S_SEND;
            S_SEND: if (idx_q == LAST_IDX) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= S_IDLE;
            idx_q       <= '0;
            held_q      <= 1'b0;
            held_conf_q <= '0;
        end else begin
            state_q <= state_d;
            if (fire_o)
                idx_q <= '0;
            else if (state_q == S_SEND)
                idx_q <= idx_q + 1'b1;
            if (state_q == S_SEND || held_q) begin
                if (beat_valid_i) begin
                    held_q      <= 1'b1;
                    held_conf_q <= beat_conf_i;
                end else if (state_q == S_IDLE) begin
                    held_q <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        rep_valid_o = (state_q == S_SEND);
        rep_idx_o   = idx_q;
    end
endmodule

// File: rtl/met_tracker.sv
module met_tracker #(
    parameter int NUM_MET   = 4,
    parameter int PHASE_W   = 16,
    parameter int CONF_W    = 8,
    parameter int GAIN_SH   = 8,
    parameter int STEP_BASE = 1024,
    parameter int STEP_INC  = 256,
    parameter int IDX_W     = (NUM_MET > 1) ? $clog2(NUM_MET) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sample_tick_i,
    input  logic               beat_valid_i,
    input  logic [CONF_W-1:0]  beat_conf_i,
    input  logic               tempo_wr_i,
    input  logic [IDX_W-1:0]   tempo_idx_i,
    input  logic [PHASE_W-1:0] tempo_step_i,
    output logic [NUM_MET-1:0] met_tick_o,
    output logic               rep_valid_o,
    output logic [IDX_W-1:0]   rep_idx_o,
    output logic [PHASE_W-1:0] rep_err_o
);
    logic              fire_w;
    logic [CONF_W-1:0] fire_conf_w;
    logic [PHASE_W-1:0] err_arr [NUM_MET];

    met_rpt_seq #(
        .NUM_MET(NUM_MET), .CONF_W(CONF_W), .IDX_W(IDX_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .beat_valid_i(beat_valid_i), .beat_conf_i(beat_conf_i),
        .fire_o(fire_w), .fire_conf_o(fire_conf_w),
        .rep_valid_o(rep_valid_o), .rep_idx_o(rep_idx_o)
    );

    for (genvar g = 0; g < NUM_MET; g++) begin : g_osc
        met_osc #(
            .PHASE_W(PHASE_W), .CONF_W(CONF_W), .GAIN_SH(GAIN_SH),
            .RST_STEP(STEP_BASE + g * STEP_INC)
        ) u_osc (
            .clk(clk), .rst_n(rst_n),
            .tick_i(sample_tick_i),
            .fire_i(fire_w), .conf_i(fire_conf_w),
            .wr_i(tempo_wr_i && (tempo_idx_i == IDX_W'(g))),
            .wr_step_i(tempo_step_i),
            .tick_o(met_tick_o[g]),
            .err_o(err_arr[g])
        );
    end

    assign rep_err_o = err_arr[rep_idx_o];
endmodule

// File: rtl/met_tracker_chk.sv
module met_tracker_chk #(
    parameter int NUM_MET = 4,
    parameter int IDX_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sample_tick_i,
    input logic               fire,
    input logic               rep_valid_o,
    input logic [IDX_W-1:0]   rep_idx_o,
    input logic [NUM_MET-1:0] met_tick_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_MET - 1);

    // R1: a beat pulse only follows a cycle with a sample tick
    a_r1_tick_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (|met_tick_o) |-> $past(sample_tick_i));

    // R6: a burst starts at index 0
    a_r6_first_index: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rep_valid_o) |-> (rep_idx_o == '0));

    // R6: indices step by one inside a burst
    a_r6_index_order: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_valid_o && rep_idx_o != LAST_IDX) |=>
            (rep_valid_o && rep_idx_o == $past(rep_idx_o) + 1'b1));

    // R6: the burst ends after the last index
    a_r6_burst_end: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_valid_o && rep_idx_o == LAST_IDX) |=> !rep_valid_o);

    // R7: no event fires while a burst runs
    a_r7_no_fire_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rep_valid_o |-> !fire);

    // R7: every fired event is followed by its burst
    a_r7_fire_reports: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (rep_valid_o && rep_idx_o == '0));
endmodule

bind met_tracker met_tracker_chk #(.NUM_MET(NUM_MET), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sample_tick_i(sample_tick_i), .fire(fire_w),
    .rep_valid_o(rep_valid_o), .rep_idx_o(rep_idx_o), .met_tick_o(met_tick_o)
);

// File: tb/tb_met_tracker.sv
module tb_met_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int NM = 4;
    localparam longint FULL = 65536;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_tick_i = 1'b0, beat_valid_i = 1'b0, tempo_wr_i = 1'b0;
    logic [7:0]  beat_conf_i = '0;
    logic [1:0]  tempo_idx_i = '0;
    logic [15:0] tempo_step_i = '0;
    logic [NM-1:0] met_tick_o;
    logic        rep_valid_o;
    logic [1:0]  rep_idx_o;
    logic [15:0] rep_err_o;

    met_tracker dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc_cnt = 0;
    longint mph[NM], mstep[NM], mpend[NM], experr[NM], saved[NM];
    bit     mpv[NM];

    localparam int TBL[7][2] = '{
        '{5, 255}, '{20, 128}, '{33, 64}, '{70, 0}, '{12, 200}, '{90, 17}, '{1, 255}
    };

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc_cnt, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // one cycle: drive, advance the model, then check beat pulses (R1, R5, R8)
    task automatic cyc(input bit tk, input bit bv, input int conf, input bit mfire,
                       input int mconf, input bit wr, input int widx, input int wstep);
        logic [NM-1:0] expt;
        sample_tick_i = tk; beat_valid_i = bv; beat_conf_i = 8'(conf);
        tempo_wr_i = wr; tempo_idx_i = 2'(widx); tempo_step_i = 16'(wstep);
        for (int i = 0; i < NM; i++) begin
            longint base, sum, e;
            base = mph[i];
            if (mfire) begin
                e = (mph[i] >= FULL/2) ? mph[i] - FULL : mph[i];
                experr[i] = e;
                base = (mph[i] - ((e * mconf) >>> 8)) & (FULL - 1);
            end
            sum = base + (tk ? mstep[i] : 0);
            expt[i] = tk && (sum >= FULL);
            if (expt[i] && mpv[i]) begin mstep[i] = mpend[i]; mpv[i] = 1'b0; end
            mph[i] = sum & (FULL - 1);
            if (wr && widx == i) begin mpend[i] = wstep; mpv[i] = 1'b1; end
        end
        @(posedge clk); @(negedge clk);
        check(met_tick_o == expt, "R1 R5 R8 tick", met_tick_o, expt);
    endtask

    task automatic idle(); cyc(0, 0, 0, 0, 0, 0, 0, 0); endtask

    // R6 R3 R4: check one full burst against the model errors
    task automatic burst();
        for (int i = 0; i < NM; i++) begin
            check(rep_valid_o == 1'b1, "R6 valid", rep_valid_o, 1);
            check(rep_idx_o == 2'(i), "R6 index", rep_idx_o, i);
            check(longint'($signed(rep_err_o)) == experr[i], "R3 R4 error",
                  $signed(rep_err_o), experr[i]);
            idle();
        end
        check(rep_valid_o == 1'b0, "R6 end", rep_valid_o, 0);
    endtask

    task automatic beat(input int conf);
        cyc(0, 1, conf, 1, conf, 0, 0, 0);
        burst();
    endtask

    initial begin
        for (int i = 0; i < NM; i++) begin
            mph[i] = 0; mstep[i] = 1024 + i * 256; mpv[i] = 1'b0; mpend[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state
        check(rep_valid_o == 1'b0, "R2 valid", rep_valid_o, 0);
        check(met_tick_o == '0, "R2 tick", met_tick_o, 0);
        beat(200);
        for (int i = 0; i < NM; i++)
            check(experr[i] == 0, "R2 zero error", experr[i], 0);

        // table walk: ticks then a beat (R1 R3 R4 R6)
        for (int t = 0; t < 7; t++) begin
            for (int k = 0; k < TBL[t][0]; k++) cyc(1, 0, 0, 0, 0, 0, 0, 0);
            beat(TBL[t][1]);
        end

        // R3: fold, metronome 3 beyond half a period gives a negative error
        for (int k = 0; k < 20; k++) cyc(1, 0, 0, 0, 0, 0, 0, 0);
        beat(0);
        check(experr[3] < 0, "R3 fold negative", experr[3], -1);
        for (int i = 0; i < NM; i++) saved[i] = experr[i];
        // R4: zero confidence left phases untouched
        beat(0);
        for (int i = 0; i < NM; i++)
            check(experr[i] == saved[i], "R4 zero confidence", experr[i], saved[i]);

        // R5: beat and tick in one cycle
        for (int k = 0; k < 9; k++) cyc(1, 0, 0, 0, 0, 0, 0, 0);
        cyc(1, 1, 180, 1, 180, 0, 0, 0);
        burst();
        beat(255);

        // R7: beat during a burst is held
        for (int k = 0; k < 15; k++) cyc(1, 0, 0, 0, 0, 0, 0, 0);
        cyc(0, 1, 230, 1, 230, 0, 0, 0);
        for (int i = 0; i < NM; i++) begin
            check(rep_valid_o == 1'b1, "R7 first burst", rep_valid_o, 1);
            check(longint'($signed(rep_err_o)) == experr[i], "R7 first error",
                  $signed(rep_err_o), experr[i]);
            if (i == 1) cyc(1, 1, 100, 0, 0, 0, 0, 0);
            else        cyc(1, 0, 0, 0, 0, 0, 0, 0);
        end
        check(rep_valid_o == 1'b0, "R7 gap", rep_valid_o, 0);
        cyc(1, 0, 0, 1, 100, 0, 0, 0);
        burst();

        // R8: reload metronome 1 mid-period, then watch wraps
        for (int k = 0; k < 7; k++) cyc(1, 0, 0, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 1, 1, 16'h1800);
        for (int k = 0; k < 300; k++) cyc(1, 0, 0, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 1, 2, 16'h0123);
        for (int k = 0; k < 400; k++) cyc(1, 0, 0, 0, 0, 0, 0, 0);
        beat(90);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule